// File: doc/BRIEF.md
# Table-Driven Door-Lock Sequence Machine

This block is a small clocked state machine whose whole next-state and output logic sits in an address-indexed lookup table rather than in gates. On every clock edge a three-bit register captures the table word selected by the present state and one external input bit. The upper two bits of that word become the next present state, and the lowest bit becomes the registered unlock output.

The table contents are computed at elaboration from an encoded transition table for a door-lock sequence detector. The meaningful states are 01 (start), 10 and 11. The unused code 00 has its rows filled so that the machine always returns to the start state on the next edge. The table may be built one bit wider on both address and data, zero-padded, and the extra bit has no effect on behaviour.

Top module: `rom_lock_fsm`

## Requirements
- R1: The table address is packed as {state[1], state[0], doorIn}, with the input bit as the least significant bit. With the default padding, an extra address bit above these three is tied to zero.
- R2: The table word is packed as {nextState[1], nextState[0], unlock}. On each clock edge out of reset, its upper two bits load stateOut and its bit 0 loads unlockOut.
- R3: From the start state 01, doorIn=0 moves to state 10 and doorIn=1 stays in 01, both with unlockOut=0.
- R4: A synchronous active-high rst loads stateOut=00 and unlockOut=0 at the clock edge.
- R5: From state 00, either input value moves the machine to state 01 with unlockOut=0 at the next edge.
- R6: From state 10, doorIn=1 moves to 11 and doorIn=0 moves to 01, both with unlockOut=0.
- R7: From state 11, doorIn=0 moves to 01 with unlockOut=1, and doorIn=1 moves to 01 with unlockOut=0.
- R8: unlockOut and stateOut are registered. They change only at a clock edge, one cycle after the state and input that select them, and never between edges.
- R9: The padded table (PAD_W=1) and the unpadded table (PAD_W=0) give the same output sequence for every input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| doorIn | input | 1 | Serial input bit of the sequence |
| unlockOut | output | 1 | Registered unlock pulse |
| stateOut | output | 2 | Registered present state code |

## Verification
The checker tests the following on every cycle:
- the reset load;
- the one-edge recovery out of code 00;
- the advance from the start state on input 0;
- the rule that unlockOut can only follow state 11 with input 0 and always coincides with the start state;
- the rule that the state never returns to 00 outside reset.

Some properties can only be shown by the bench's scenarios:
- the full transition table, compared against a reference case model under several input streams;
- that both outputs stay unchanged when the input moves between edges;
- that the padded and unpadded table builds behave identically.

// File: rtl/lock_rom_pkg.sv
package lock_rom_pkg;

  localparam int STATE_W = 2;
  localparam int CORE_AW = STATE_W + 1;
  localparam int CORE_DW = STATE_W + 1;

  localparam logic [STATE_W-1:0] START_CODE  = 2'b01;
  localparam logic [STATE_W-1:0] UNUSED_CODE = 2'b00;

  typedef struct packed {
    logic clearReg;
    logic loadReg;
  } regStrobe_t;

  // Encoded transition table: address {state, in} -> word {next, unlock}
  function automatic logic [CORE_DW-1:0] coreWord(input logic [CORE_AW-1:0] addr);
    logic [CORE_DW-1:0] w;
    case (addr)
      3'b000:  w = 3'b010;  // code 00 recovers to start
      3'b001:  w = 3'b010;
      3'b010:  w = 3'b100;  // start, 0 -> 10
      3'b011:  w = 3'b010;  // start, 1 -> start
      3'b100:  w = 3'b010;  // 10, 0 -> start
      3'b101:  w = 3'b110;  // 10, 1 -> 11
      3'b110:  w = 3'b011;  // 11, 0 -> start with unlock
      3'b111:  w = 3'b010;  // 11, 1 -> start
      default: w = 3'b010;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/lock_rom_table.sv
module lock_rom_table
  import lock_rom_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);

  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] romArray [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : gRow
    localparam logic [ADDR_W-1:0] ROW_ADDR = ADDR_W'(i);
    if (i < 2 ** CORE_AW) begin : gCore
      assign romArray[i] = DATA_W'(coreWord(ROW_ADDR[CORE_AW-1:0]));
    end else begin : gPad
      // rows behind a nonzero pad bit still point to the start state
      assign romArray[i] = DATA_W'({START_CODE, 1'b0});
    end
  end

  assign word = romArray[addr];

endmodule

// File: rtl/lock_rom_ctrl.sv
module lock_rom_ctrl
  import lock_rom_pkg::*;
(
  input  logic       rst,
  output regStrobe_t strobe
);

  always_comb begin
    strobe.clearReg = rst;
    strobe.loadReg  = !rst;
  end

endmodule

// File: rtl/lock_rom_path.sv
module lock_rom_path
  import lock_rom_pkg::*;
#(
  parameter int PAD_W = 1
) (
  input  logic               clk,
  input  regStrobe_t         strobe,
  input  logic               doorIn,
  output logic [STATE_W-1:0] stateQ,
  output logic               unlockQ
);

  localparam int MEM_AW = CORE_AW + PAD_W;
  localparam int MEM_DW = CORE_DW + PAD_W;

  logic [MEM_AW-1:0]  romAddr;
  logic [MEM_DW-1:0]  romWord;
  logic [CORE_DW-1:0] dataQ;

  // address packing: pad bits zero, then state, input as LSB
  assign romAddr = MEM_AW'({stateQ, doorIn});

  lock_rom_table #(
    .ADDR_W(MEM_AW),
    .DATA_W(MEM_DW)
  ) uTable (
    .addr(romAddr),
    .word(romWord)
  );

  if (PAD_W > 0) begin : gPadSink
    logic [PAD_W-1:0] unusedPadBits;
    assign unusedPadBits = romWord[MEM_DW-1:CORE_DW];
  end

  always_ff @(posedge clk) begin
    if (strobe.clearReg) begin
      dataQ <= '0;
    end else if (strobe.loadReg) begin
      dataQ <= romWord[CORE_DW-1:0];
    end
  end

  assign stateQ  = dataQ[CORE_DW-1:1];
  assign unlockQ = dataQ[0];

endmodule

// File: rtl/rom_lock_fsm.sv
module rom_lock_fsm
  import lock_rom_pkg::*;
#(
  parameter int PAD_W = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       doorIn,
  output logic       unlockOut,
  output logic [1:0] stateOut
);

  regStrobe_t strobe;

  lock_rom_ctrl uCtrl (
    .rst   (rst),
    .strobe(strobe)
  );

  lock_rom_path #(
    .PAD_W(PAD_W)
  ) uPath (
    .clk    (clk),
    .strobe (strobe),
    .doorIn (doorIn),
    .stateQ (stateOut),
    .unlockQ(unlockOut)
  );

endmodule

// File: rtl/rom_lock_fsm_chk.sv
module rom_lock_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       doorIn,
  input logic       unlockOut,
  input logic [1:0] stateOut
);

  logic seenEdge;
  logic rstPrev;

  always_ff @(posedge clk) begin
    seenEdge <= 1'b1;
    rstPrev  <= rst;
  end

  // R4: reset loads 00 with no unlock
  always_ff @(negedge clk) begin
    if (seenEdge === 1'b1 && rstPrev === 1'b1) begin
      a_r4_reset_load: assert (stateOut == 2'b00 && !unlockOut)
        else $error("a_r4_reset_load");
    end
  end

  // R5: code 00 recovers on the next edge
  a_r5_recover: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 2'b00) |=> (stateOut == 2'b01 && !unlockOut));

  // R3: start with input 0 advances to 10
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (stateOut == 2'b01 && !doorIn) |=> (stateOut == 2'b10 && !unlockOut));

  // R7: unlock only follows state 11 with input 0
  a_r7_unlock_source: assert property (@(posedge clk) disable iff (rst)
    unlockOut |-> ($past(stateOut) == 2'b11 && !$past(doorIn)));

  // R2: unlock coincides with the start state
  a_r2_unlock_in_start: assert property (@(posedge clk) disable iff (rst)
    unlockOut |-> (stateOut == 2'b01));

  // R5: outside reset the machine never re-enters 00
  a_r5_no_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stateOut != 2'b00));

endmodule

bind rom_lock_fsm rom_lock_fsm_chk uChk (.*);

// File: tb/tb_rom_lock_fsm.sv
module tb_rom_lock_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       doorIn = 1'b0;
  logic       unlockOut, unlockNarrow;
  logic [1:0] stateOut, stateNarrow;

  int checks = 0;
  int errors = 0;

  logic [1:0] refState = 2'b00;
  logic       refUnlock = 1'b0;

  always #10 clk = ~clk;

  rom_lock_fsm #(.PAD_W(1)) dut (
    .clk(clk), .rst(rst), .doorIn(doorIn),
    .unlockOut(unlockOut), .stateOut(stateOut)
  );

  rom_lock_fsm #(.PAD_W(0)) dutNarrow (
    .clk(clk), .rst(rst), .doorIn(doorIn),
    .unlockOut(unlockNarrow), .stateOut(stateNarrow)
  );

  // reference model from the requirements
  task automatic refStep(input logic rIn, input logic din);
    if (rIn) begin
      refState = 2'b00; refUnlock = 1'b0;
    end else begin
      refUnlock = 1'b0;
      case (refState)
        2'b00: refState = 2'b01;
        2'b01: refState = din ? 2'b01 : 2'b10;
        2'b10: refState = din ? 2'b11 : 2'b01;
        default: begin
          refUnlock = !din;
          refState  = 2'b01;
        end
      endcase
    end
  endtask

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive at negedge, let an edge pass, sample 2ns after it
  task automatic step(input logic rIn, input logic din);
    @(negedge clk);
    rst = rIn; doorIn = din;
    @(posedge clk);
    refStep(rIn, din);
    #2;
  endtask

  task automatic stepCheck(input string req, input logic rIn, input logic din);
    step(rIn, din);
    check(req, {stateOut, unlockOut}, {refState, refUnlock});
  endtask

  task automatic doReset();
    stepCheck("R4", 1'b1, 1'b0);
    check("R4", {stateOut, unlockOut}, 3'b000);
  endtask

  task automatic testReset();
    doReset();
    stepCheck("R5", 1'b0, 1'b1);
    check("R5", {stateOut, unlockOut}, 3'b010);
    doReset();
    stepCheck("R5", 1'b0, 1'b0);
    check("R5", {stateOut, unlockOut}, 3'b010);
  endtask

  task automatic testStart();
    stepCheck("R3", 1'b0, 1'b1);
    check("R3", {stateOut, unlockOut}, 3'b010);
    stepCheck("R3", 1'b0, 1'b0);
    check("R3", {stateOut, unlockOut}, 3'b100);
  endtask

  task automatic testMiddle();
    stepCheck("R6", 1'b0, 1'b0);
    check("R6", {stateOut, unlockOut}, 3'b010);
    stepCheck("R6", 1'b0, 1'b0);
    stepCheck("R6", 1'b0, 1'b1);
    check("R6", {stateOut, unlockOut}, 3'b110);
  endtask

  task automatic testUnlock();
    stepCheck("R7", 1'b0, 1'b0);
    check("R7", {stateOut, unlockOut}, 3'b011);
    stepCheck("R2", 1'b0, 1'b1);
    check("R2", {stateOut, unlockOut}, 3'b010);
    stepCheck("R7", 1'b0, 1'b0);
    stepCheck("R7", 1'b0, 1'b1);
    stepCheck("R7", 1'b0, 1'b1);
    check("R7", {stateOut, unlockOut}, 3'b010);
  endtask

  task automatic testRegistered();
    // reach 11, then toggle the input between edges
    stepCheck("R8", 1'b0, 1'b0);
    stepCheck("R8", 1'b0, 1'b1);
    check("R8", {stateOut, unlockOut}, 3'b110);
    #3 doorIn = 1'b0;
    #2 check("R8", {stateOut, unlockOut}, 3'b110);
    doorIn = 1'b1;
    #2 check("R8", {stateOut, unlockOut}, 3'b110);
    doorIn = 1'b0;
    @(posedge clk);
    refStep(1'b0, 1'b0);
    #2 check("R8", {stateOut, unlockOut}, 3'b011);
  endtask

  task automatic testRandom(input int seed, input int len);
    int s = seed;
    for (int i = 0; i < len; i++) begin
      logic din;
      din = 1'($urandom(s));
      s = s + 1;
      stepCheck("R1", 1'b0, din);
      check("R9", {stateNarrow, unlockNarrow}, {stateOut, unlockOut});
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testStart();
    testMiddle();
    testUnlock();
    testRegistered();
    doReset();
    testRandom(7, 200);
    doReset();
    testRandom(1234, 300);
    finishRun();
  end

endmodule